// File: doc/BRIEF.md
# Past-Time Temporal Property Monitor

This block watches a stream of event steps and decides, on every step, whether a fixed past-time temporal property still holds. Each step is marked by a one-cycle strobe that comes with a vector of event bits. The monitor keeps one state bit for each temporal operator in the property and updates every state bit together when the strobe is high. The verdict for a step is formed from the next-state values of those bits. The current event therefore counts toward its own verdict, and no step of lag is added.

The property is chosen at elaboration time by the `FORMULA` parameter. The operands are taken from the event vector at positions `A_IDX` and `B_IDX`. Four properties are offered: a guarded "at some earlier or current step", a plain "at every step", a guarded "at the step just before", and "A since B". The verdict leaves the block through output registers: a held result level plus one pulse for a pass and one pulse for a fail. A recovery unit downstream can act on those pulses.

Top module: `ptl_monitor`

## Requirements
- R1: While `rst_i` is high and in the first cycle after it, `result_o`, `pass_o` and `fail_o` are 0. Reset starts each "at every step" state as true, each "at some step" state as false, each "just before" state as false and each "since" state as false.
- R2: A clock cycle with `step_i` low changes no state and raises no pulse, whatever `ev_i` carries. In the following cycle `result_o` keeps its value and `pass_o` and `fail_o` are 0.
- R3: A cycle with `step_i` high gives exactly one of `pass_o` or `fail_o` in the next cycle, for that one cycle only. In that cycle `result_o` equals `pass_o`.
- R4: With `FORMULA`=0, the verdict for a step is true when `ev_i[B_IDX]` is low, or when `ev_i[A_IDX]` was high on any step since reset, this step included.
- R5: With `FORMULA`=1, the verdict for a step is true only if `ev_i[A_IDX]` has been high on every step since reset, this step included. Once it has failed, it never passes again before reset.
- R6: With `FORMULA`=2, the verdict for a step is true when `ev_i[B_IDX]` is low, or when `ev_i[A_IDX]` was high on the step just before. Idle cycles between steps do not count as steps. On the first step after reset the "just before" value is false.
- R7: With `FORMULA`=3, the verdict for a step is true when `ev_i[B_IDX]` is high on this step. It is also true when `ev_i[A_IDX]` is high on this step and the verdict of the previous step was true. Otherwise it is false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Event step strobe |
| ev_i | input | NUM_EV | Event bits sampled on a step |
| result_o | output | 1 | Verdict of the latest step, held between steps |
| pass_o | output | 1 | One-cycle pulse: the latest step satisfied the property |
| fail_o | output | 1 | One-cycle pulse: the latest step violated the property |

## Verification
One copy of the block is built for each property value, and all copies see the same event stream. Directed steps set the operands together in one step and then in separate steps. This separates same-step substitution (R4, R7) from a one-step-late design, and "just before" (R6) from "at any earlier step". Idle cycles with busy event bits show whether state moves without a strobe. A mid-run reset shows whether the sticky bits are cleared. A long pseudo-random stream of steps and gaps is then compared cycle by cycle against a behavioural model in the bench.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

  typedef enum logic [1:0] {
    OP_ALWAYS     = 2'd0,
    OP_EVENTUALLY = 2'd1,
    OP_PREVIOUSLY = 2'd2,
    OP_SINCE      = 2'd3
  } ptl_op_e;

  // Property selector values
  localparam int unsigned FML_GUARD_EVER = 0;  // B -> ever(A)
  localparam int unsigned FML_ALWAYS     = 1;  // always(A)
  localparam int unsigned FML_GUARD_PREV = 2;  // B -> prev(A)
  localparam int unsigned FML_SINCE      = 3;  // A since B
  localparam int unsigned FML_COUNT      = 4;

  function automatic logic op_init(ptl_op_e op);
    return (op == OP_ALWAYS);
  endfunction

endpackage

// File: rtl/ptl_op_cell.sv
// One temporal operator: one state bit, parallel update on a step.
// val_o is the operator value for the present step.
module ptl_op_cell
  import ptl_pkg::*;
#(
  parameter ptl_op_e OP = OP_EVENTUALLY
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  input  logic a_i,
  input  logic b_i,
  output logic val_o
);

  localparam logic INIT = op_init(OP);

  logic st_q;
  logic st_nxt;
  logic unused_b;

  generate
    if (OP == OP_ALWAYS) begin : g_always
      assign st_nxt   = st_q & a_i;
      assign val_o    = st_nxt;
      assign unused_b = b_i;
    end else if (OP == OP_EVENTUALLY) begin : g_ever
      assign st_nxt   = st_q | a_i;
      assign val_o    = st_nxt;
      assign unused_b = b_i;
    end else if (OP == OP_PREVIOUSLY) begin : g_prev
      // holds A of this step; the value seen now is the stored one
      assign st_nxt   = a_i;
      assign val_o    = st_q;
      assign unused_b = b_i;
    end else begin : g_since
      assign st_nxt   = b_i | (a_i & st_q);
      assign val_o    = st_nxt;
      assign unused_b = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q <= INIT;
    end else if (step_i) begin
      st_q <= st_nxt;
    end
  end

endmodule

// File: rtl/ptl_formula.sv
// Builds the selected property from operator cells.
module ptl_formula
  import ptl_pkg::*;
#(
  parameter int unsigned NUM_EV  = 4,
  parameter int unsigned FORMULA = FML_GUARD_EVER,
  parameter int unsigned A_IDX   = 0,
  parameter int unsigned B_IDX   = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              step_i,
  input  logic [NUM_EV-1:0] ev_i,
  output logic              holds_o
);

  localparam ptl_op_e CELL_OP =
    (FORMULA == FML_ALWAYS)     ? OP_ALWAYS     :
    (FORMULA == FML_GUARD_PREV) ? OP_PREVIOUSLY :
    (FORMULA == FML_SINCE)      ? OP_SINCE      : OP_EVENTUALLY;

  logic ev_a;
  logic ev_b;
  logic cell_val;
  logic unused_ev;

  assign ev_a      = ev_i[A_IDX];
  assign ev_b      = ev_i[B_IDX];
  assign unused_ev = ^ev_i;

  ptl_op_cell #(.OP(CELL_OP)) i_cell (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .step_i(step_i),
    .a_i   (ev_a),
    .b_i   (ev_b),
    .val_o (cell_val)
  );

  generate
    if (FORMULA == FML_GUARD_EVER || FORMULA == FML_GUARD_PREV) begin : g_guard
      assign holds_o = ~ev_b | cell_val;
    end else begin : g_plain
      assign holds_o = cell_val;
    end
  endgenerate

endmodule

// File: rtl/ptl_verdict.sv
// Registers the verdict of a step as a level and a pass/fail pulse.
module ptl_verdict (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  input  logic holds_i,
  output logic result_o,
  output logic pass_o,
  output logic fail_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_o <= 1'b0;
      pass_o   <= 1'b0;
      fail_o   <= 1'b0;
    end else begin
      pass_o <= step_i & holds_i;
      fail_o <= step_i & ~holds_i;
      if (step_i) begin
        result_o <= holds_i;
      end
    end
  end

endmodule

// File: rtl/ptl_monitor.sv
module ptl_monitor
  import ptl_pkg::*;
#(
  parameter int unsigned NUM_EV  = 4,
  parameter int unsigned FORMULA = FML_GUARD_EVER,
  parameter int unsigned A_IDX   = 0,
  parameter int unsigned B_IDX   = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              step_i,
  input  logic [NUM_EV-1:0] ev_i,
  output logic              result_o,
  output logic              pass_o,
  output logic              fail_o
);

  logic holds;

  ptl_formula #(
    .NUM_EV (NUM_EV),
    .FORMULA(FORMULA),
    .A_IDX  (A_IDX),
    .B_IDX  (B_IDX)
  ) i_formula (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (step_i),
    .ev_i   (ev_i),
    .holds_o(holds)
  );

  ptl_verdict i_verdict (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .step_i  (step_i),
    .holds_i (holds),
    .result_o(result_o),
    .pass_o  (pass_o),
    .fail_o  (fail_o)
  );

endmodule

// File: rtl/ptl_monitor_chk.sv
module ptl_monitor_chk #(
  parameter int unsigned NUM_EV  = 4,
  parameter int unsigned FORMULA = 0,
  parameter int unsigned A_IDX   = 0,
  parameter int unsigned B_IDX   = 1
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              step_i,
  input logic [NUM_EV-1:0] ev_i,
  input logic              result_o,
  input logic              pass_o,
  input logic              fail_o
);

  logic ever_failed;

  always_ff @(posedge clk_i) begin
    if (rst_i) ever_failed <= 1'b0;
    else if (fail_o) ever_failed <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!pass_o && !fail_o && !result_o)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> (!pass_o && !fail_o && $stable(result_o))); // R2

  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i |=> $countones({pass_o, fail_o}) == 1); // R3

  AST_RESULT_AGREES: assert property (@(posedge clk_i) disable iff (rst_i)
    (pass_o || fail_o) |-> (result_o == pass_o)); // R3

  AST_EVER_UNGUARDED: assert property (@(posedge clk_i) disable iff (rst_i)
    (FORMULA == 0 && step_i && !ev_i[B_IDX]) |=> pass_o); // R4

  AST_ALWAYS_FAILS: assert property (@(posedge clk_i) disable iff (rst_i)
    (FORMULA == 1 && step_i && !ev_i[A_IDX]) |=> fail_o); // R5

  AST_ALWAYS_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (FORMULA == 1 && ever_failed) |-> !pass_o); // R5

  AST_PREV_UNGUARDED: assert property (@(posedge clk_i) disable iff (rst_i)
    (FORMULA == 2 && step_i && !ev_i[B_IDX]) |=> pass_o); // R6

  AST_SINCE_ANCHOR: assert property (@(posedge clk_i) disable iff (rst_i)
    (FORMULA == 3 && step_i && ev_i[B_IDX]) |=> pass_o); // R7

  AST_SINCE_BREAK: assert property (@(posedge clk_i) disable iff (rst_i)
    (FORMULA == 3 && step_i && !ev_i[A_IDX] && !ev_i[B_IDX]) |=> fail_o); // R7

endmodule

bind ptl_monitor ptl_monitor_chk #(
  .NUM_EV (NUM_EV),
  .FORMULA(FORMULA),
  .A_IDX  (A_IDX),
  .B_IDX  (B_IDX)
) i_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .step_i  (step_i),
  .ev_i    (ev_i),
  .result_o(result_o),
  .pass_o  (pass_o),
  .fail_o  (fail_o)
);

// File: tb/test_ptl_monitor.sv
`timescale 1ns/1ps
module test_ptl_monitor;

  localparam int NF = 4;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step = 1'b0;
  logic [NE-1:0] ev = '0;
  logic          res [NF];
  logic          pas [NF];
  logic          fal [NF];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  for (genvar gk = 0; gk < NF; gk++) begin : gen_f
    ptl_monitor #(.NUM_EV(NE), .FORMULA(gk), .A_IDX(0), .B_IDX(1)) i_ptl_monitor (
      .clk_i(clk), .rst_i(rst), .step_i(step), .ev_i(ev),
      .result_o(res[gk]), .pass_o(pas[gk]), .fail_o(fal[gk])
    );
  end

  // Behavioural reference model
  bit    m_ever, m_all, m_prev, m_since;
  bit    e_res [NF];
  bit    e_pas [NF];
  bit    e_fal [NF];
  string tag_res [NF];
  string tag_pls;

  function automatic string fml_tag(int k);
    case (k)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    bit a, b;
    bit h [NF];
    a = ev[0];
    b = ev[1];
    started <= 1'b1;
    if (rst) begin
      m_ever = 0; m_all = 1; m_prev = 0; m_since = 0;
      tag_pls = "R1";
      for (int k = 0; k < NF; k++) begin
        e_res[k] = 0; e_pas[k] = 0; e_fal[k] = 0; tag_res[k] = "R1";
      end
    end else if (step) begin
      m_ever = m_ever | a;
      h[0] = !b || m_ever;
      m_all = m_all & a;
      h[1] = m_all;
      h[2] = !b || m_prev;
      m_prev = a;
      m_since = b || (a && m_since);
      h[3] = m_since;
      tag_pls = "R3";
      for (int k = 0; k < NF; k++) begin
        e_res[k] = h[k]; e_pas[k] = h[k]; e_fal[k] = !h[k]; tag_res[k] = fml_tag(k);
      end
    end else begin
      tag_pls = "R2";
      for (int k = 0; k < NF; k++) begin
        e_pas[k] = 0; e_fal[k] = 0; tag_res[k] = "R2";
      end
    end
  end

  task automatic check1(string tag, string what, int k, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s formula=%0d %s actual=%b expected=%b t=%0t", tag, k, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int k = 0; k < NF; k++) begin
        check1(tag_res[k], "result", k, res[k], e_res[k]);
        check1(tag_pls, "pass", k, pas[k], e_pas[k]);
        check1(tag_pls, "fail", k, fal[k], e_fal[k]);
      end
    end
  end

  // Stimulus
  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic do_step(bit a, bit b, logic [1:0] hi);
    @(negedge clk);
    step = 1'b1;
    ev = {hi, b, a};
    @(negedge clk);
    step = 1'b0;
    ev = ~ev;  // idle noise that must be ignored (R2)
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step = 1'b0;
      ev = ev + 4'd5;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: first steps after reset (always true, prev false, since false)
    do_step(1, 0, 2'b00);
    do_step(1, 0, 2'b11);
    // grant without earlier request; R6 sees A from last step
    do_step(0, 1, 2'b00);
    idle(3);
    // R7: since chain then break
    do_step(1, 0, 2'b10);
    do_step(0, 0, 2'b01);
    // R4/R7: both in the same step
    do_step(1, 1, 2'b00);
    do_step(1, 0, 2'b00);
    idle(2);
    do_step(0, 1, 2'b00);
    // R1: mid-run reset clears sticky state
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    do_step(0, 1, 2'b11);   // R4: no earlier A -> fail; R6: first step prev false
    do_step(1, 1, 2'b00);   // R4: same-step A -> pass
    do_step(0, 1, 2'b00);   // R6: A was high just before
    idle(5);
    do_step(0, 1, 2'b00);   // R6: idle gap does not count, prev A was 0
    // Pseudo-random phase
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr_next(lfsr);
      if (lfsr[0] | lfsr[5]) begin
        do_step(lfsr[1] | lfsr[7], lfsr[2], lfsr[4:3]);
      end else begin
        idle(1 + lfsr[9:8]);
      end
      if (lfsr[15:11] == 5'd0) begin
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
      end
    end
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule